// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine of a 32-bit datapath. It keeps its results in two dedicated result registers, HI and LO, which together form a 64-bit pair. An operation is issued by raising a start strobe together with a 4-bit operation code and two operands. Full multiplies overwrite the pair with a 64-bit product. Multiply-add and multiply-subtract use the pair as a 64-bit accumulator. Divides leave the quotient in LO and the remainder in HI.

Reads of HI or LO, and a family of 32-bit multiplies that return only the low half of the product, deliver their result on a 32-bit read port. The 32-bit multiplies also report an overflow flag. Multiplies, accumulates and reads finish in one cycle. A divide runs as a restoring shift-subtract loop that takes one cycle per operand bit. A busy output is high while the divide runs, and requests made in that time are dropped. No operation ever traps: all overflow either wraps or is reported on the flag.

Top module: `hilo_muldiv`

## Requirements
- R1: An operation is taken only on a rising clock edge where `start_i` is 1 and `busy_o` is 0. The operation codes are 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 signed multiply-add, 5 unsigned multiply-add, 6 signed multiply-subtract, 7 unsigned multiply-subtract, 8 read HI, 9 read LO, 10 low multiply, 11 low multiply with signed overflow, and 12 low multiply with unsigned overflow. With `start_i` at 0, HI and LO do not change.
- R2: Codes 0 and 1 write the 64-bit product to HI (bits 63..32) and LO (bits 31..0) one cycle after issue. Code 0 treats the operands as two's complement and code 1 treats them as unsigned.
- R3: Codes 2 and 3 write the quotient to LO and the remainder to HI. A signed divide rounds the quotient toward zero, and the remainder takes the sign of the dividend. The case 0x80000000 divided by -1 gives LO=0x80000000 and HI=0.
- R4: A divide by zero of either kind completes normally and leaves LO=0xFFFFFFFF and HI equal to the dividend.
- R5: Codes 4 and 5 add the product to HI:LO, and codes 6 and 7 subtract it. Results wrap modulo 2^64 with no other effect.
- R6: Codes 8 and 9 place HI or LO on `rd_data_o` one cycle after issue and leave HI, LO and `ovf_o` unchanged. `rd_data_o` holds its value until the next read or low multiply.
- R7: Codes 10, 11 and 12 place the low 32 bits of the product on `rd_data_o` one cycle after issue and leave HI and LO unchanged. Code 10 drives `ovf_o` to 0.
- R8: Code 11 sets `ovf_o` to 1 exactly when the signed product does not fit in 32 signed bits.
- R9: Code 12 sets `ovf_o` to 1 exactly when the high 32 bits of the unsigned product are non-zero.
- R10: `busy_o` rises on the edge that takes a divide and stays high for 33 cycles. HI and LO are written on the edge where `busy_o` falls. Every request made while `busy_o` is high is ignored.
- R11: While `rst_n` is low, HI, LO, `rd_data_o`, `ovf_o` and `busy_o` are 0. This holds even during a divide, and applies without waiting for a clock edge. Release of `rst_n` takes effect through a two-stage synchroniser.
- R12: Codes 13 to 15 change neither HI, LO, `rd_data_o` nor `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Qualifies op_i, a_i and b_i for one cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand, also the dividend |
| b_i | input | 32 | Second operand, also the divisor |
| busy_o | output | 1 | Divide in progress |
| rd_data_o | output | 32 | Result of a read or a low multiply |
| ovf_o | output | 1 | Overflow flag of the last low multiply |
| hi_o | output | 32 | Current HI register |
| lo_o | output | 32 | Current LO register |

## Verification
The bench builds the unit with the default 32-bit width and the two-stage reset synchroniser. At this width the extreme operands can all be driven. These include the largest positive value squared and accumulated until its sign flips, all-ones times all-ones subtracted from an all-ones pair, and the most negative value divided by -1. The busy window of 33 cycles can also be counted directly, and requests can be injected into it. Operands around 2^15 × 2^16 place products right on the 32-bit signed and unsigned overflow edges.

// File: rtl/hilo_pkg.sv
`timescale 1ns/1ps
package hilo_pkg;

  typedef enum logic [3:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_DIV   = 4'd2,
    OP_DIVU  = 4'd3,
    OP_MADD  = 4'd4,
    OP_MADDU = 4'd5,
    OP_MSUB  = 4'd6,
    OP_MSUBU = 4'd7,
    OP_RDHI  = 4'd8,
    OP_RDLO  = 4'd9,
    OP_MUL32 = 4'd10,
    OP_MULOS = 4'd11,
    OP_MULOU = 4'd12
  } md_op_e;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_DONE = 2'd2
  } dv_state_e;

  // operations whose product is formed from two's complement operands
  function automatic logic op_is_signed_mul(input md_op_e op);
    return (op == OP_MULT) || (op == OP_MADD) || (op == OP_MSUB) || (op == OP_MULOS);
  endfunction

  function automatic logic op_is_sub(input md_op_e op);
    return (op == OP_MSUB) || (op == OP_MSUBU);
  endfunction

endpackage

// File: rtl/hilo_mult.sv
`timescale 1ns/1ps
// Single-cycle multiplier: operands are extended by one bit according to
// the signedness request, so one array serves both interpretations.
module hilo_mult #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic              signed_i,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int PW = 2 * XLEN;

  logic signed [XLEN:0] a_ext;
  logic signed [XLEN:0] b_ext;
  logic signed [PW-1:0] full;

  always_comb begin
    a_ext = {signed_i & a_i[XLEN-1], a_i};
    b_ext = {signed_i & b_i[XLEN-1], b_i};
    full  = a_ext * b_ext;
  end

  assign prod_o = full;

endmodule

// File: rtl/hilo_acc.sv
`timescale 1ns/1ps
// 64-bit accumulate stage: adds or subtracts a product to the HI:LO pair,
// wrapping modulo 2^(2*XLEN).
module hilo_acc #(
  parameter int XLEN = 32
) (
  input  logic [2*XLEN-1:0] base_i,
  input  logic [2*XLEN-1:0] prod_i,
  input  logic              sub_i,
  output logic [2*XLEN-1:0] sum_o
);
  always_comb begin
    if (sub_i) sum_o = base_i - prod_i;
    else       sum_o = base_i + prod_i;
  end
endmodule

// File: rtl/hilo_div.sv
`timescale 1ns/1ps
// Iterative restoring divider: one quotient bit per cycle on magnitudes,
// signs applied at the output.
module hilo_div
  import hilo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  dv_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic [XLEN-1:0] dvd_raw_q, dvs_raw_q;
  logic            neg_q_q, neg_r_q, zero_q;

  logic            ld_en, it_en;
  logic            dvd_neg, dvs_neg;
  logic [XLEN-1:0] dvd_mag, dvs_mag;
  logic [XLEN:0]   shifted, diff;
  logic [XLEN-1:0] rem_nx, quo_nx;

  // operand preparation
  always_comb begin
    dvd_neg = signed_i & dvd_i[XLEN-1];
    dvs_neg = signed_i & dvs_i[XLEN-1];
    dvd_mag = dvd_neg ? (~dvd_i + 1'b1) : dvd_i;
    dvs_mag = dvs_neg ? (~dvs_i + 1'b1) : dvs_i;
  end

  // one restoring step
  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    if (!diff[XLEN]) begin
      rem_nx = diff[XLEN-1:0];
      quo_nx = {quo_q[XLEN-2:0], 1'b1};
    end else begin
      rem_nx = shifted[XLEN-1:0];
      quo_nx = {quo_q[XLEN-2:0], 1'b0};
    end
  end

  // next-state
  always_comb begin
    state_d = state_q;
    ld_en   = 1'b0;
    it_en   = 1'b0;
    case (state_q)
      DV_IDLE: if (start_i) begin
        state_d = DV_RUN;
        ld_en   = 1'b1;
      end
      DV_RUN: begin
        it_en = 1'b1;
        if (cnt_q == LAST) state_d = DV_DONE;
      end
      DV_DONE: state_d = DV_IDLE;
      default: state_d = DV_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= DV_IDLE;
      cnt_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      dvd_raw_q <= '0;
      dvs_raw_q <= '0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      zero_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_en) begin
        cnt_q     <= '0;
        rem_q     <= '0;
        quo_q     <= dvd_mag;
        dvs_q     <= dvs_mag;
        dvd_raw_q <= dvd_i;
        dvs_raw_q <= dvs_i;
        neg_q_q   <= dvd_neg ^ dvs_neg;
        neg_r_q   <= dvd_neg;
        zero_q    <= (dvs_i == '0);
      end else if (it_en) begin
        cnt_q <= cnt_q + 1'b1;
        rem_q <= rem_nx;
        quo_q <= quo_nx;
      end
    end
  end

  // sign correction and divide-by-zero result
  always_comb begin
    if (zero_q) begin
      quo_o = '1;
      rem_o = dvd_raw_q;
    end else begin
      quo_o = neg_q_q ? (~quo_q + 1'b1) : quo_q;
      rem_o = neg_r_q ? (~rem_q + 1'b1) : rem_q;
    end
  end

  assign busy_o = (state_q != DV_IDLE);
  assign done_o = (state_q == DV_DONE);

  // quotient times divisor plus remainder reproduces the dividend (mod 2^XLEN)
  logic [XLEN-1:0] recon;
  assign recon = quo_o * dvs_raw_q + rem_o;

  a_r3_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !zero_q) |-> (recon == dvd_raw_q));

  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

endmodule

// File: rtl/hilo_muldiv.sv
`timescale 1ns/1ps
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            ovf_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  localparam int PW = 2 * XLEN;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  md_op_e          op_w;
  logic            accept;
  logic            mul_signed, acc_sub;
  logic [PW-1:0]   prod, acc_sum;
  logic            sovf, uovf;

  logic            div_start, div_busy, div_done;
  logic [XLEN-1:0] div_quo, div_rem;

  logic [XLEN-1:0] hi_q, lo_q, rd_q;
  logic            ovf_q;
  logic            hilo_en, rd_en;
  logic [PW-1:0]   hilo_d;
  logic [XLEN-1:0] rd_d;
  logic            ovf_d;

  assign op_w       = md_op_e'(op_i);
  assign accept     = start_i & ~div_busy;
  assign mul_signed = op_is_signed_mul(op_w);
  assign acc_sub    = op_is_sub(op_w);

  hilo_mult #(.XLEN(XLEN)) u_mult (
    .a_i      (a_i),
    .b_i      (b_i),
    .signed_i (mul_signed),
    .prod_o   (prod)
  );

  hilo_acc #(.XLEN(XLEN)) u_acc (
    .base_i (({hi_q, lo_q})),
    .prod_i (prod),
    .sub_i  (acc_sub),
    .sum_o  (acc_sum)
  );

  hilo_div #(.XLEN(XLEN)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (div_start),
    .signed_i (op_w == OP_DIV),
    .dvd_i    (a_i),
    .dvs_i    (b_i),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .quo_o    (div_quo),
    .rem_o    (div_rem)
  );

  // overflow of a 32-bit result: signed needs bits PW-1..XLEN-1 all equal
  always_comb begin
    sovf = !((&prod[PW-1:XLEN-1]) || !(|prod[PW-1:XLEN-1]));
    uovf = |prod[PW-1:XLEN];
  end

  // next-state
  always_comb begin
    hilo_en   = 1'b0;
    hilo_d    = {hi_q, lo_q};
    rd_en     = 1'b0;
    rd_d      = rd_q;
    ovf_d     = ovf_q;
    div_start = 1'b0;
    if (div_done) begin
      hilo_en = 1'b1;
      hilo_d  = {div_rem, div_quo};
    end else if (accept) begin
      case (op_w)
        OP_MULT, OP_MULTU: begin
          hilo_en = 1'b1;
          hilo_d  = prod;
        end
        OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU: begin
          hilo_en = 1'b1;
          hilo_d  = acc_sum;
        end
        OP_DIV, OP_DIVU: div_start = 1'b1;
        OP_RDHI: begin
          rd_en = 1'b1;
          rd_d  = hi_q;
        end
        OP_RDLO: begin
          rd_en = 1'b1;
          rd_d  = lo_q;
        end
        OP_MUL32: begin
          rd_en = 1'b1;
          rd_d  = prod[XLEN-1:0];
          ovf_d = 1'b0;
        end
        OP_MULOS: begin
          rd_en = 1'b1;
          rd_d  = prod[XLEN-1:0];
          ovf_d = sovf;
        end
        OP_MULOU: begin
          rd_en = 1'b1;
          rd_d  = prod[XLEN-1:0];
          ovf_d = uovf;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (hilo_en) begin
        hi_q <= hilo_d[PW-1:XLEN];
        lo_q <= hilo_d[XLEN-1:0];
      end
      if (rd_en) begin
        rd_q  <= rd_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign busy_o    = div_busy;
  assign rd_data_o = rd_q;
  assign ovf_o     = ovf_q;
  assign hi_o      = hi_q;
  assign lo_o      = lo_q;

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !busy_o) |=> ($stable(hi_q) && $stable(lo_q)));

  a_r10_busy_after_div: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (op_i == 4'd2 || op_i == 4'd3)) |=> busy_o);

  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && !div_done) |=> ($stable(hi_q) && $stable(lo_q) && $stable(rd_q)));

  a_r6_read_hi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && op_i == 4'd8) |=> (rd_data_o == $past(hi_q) && $stable(ovf_q)));

  a_r7_low_mul_keeps_hilo: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && op_i >= 4'd10 && op_i <= 4'd12) |=> ($stable(hi_q) && $stable(lo_q)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && op_i == 4'd10) |=> !ovf_o);

  a_r12_reserved_noop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && op_i >= 4'd13) |=>
      ($stable(hi_q) && $stable(lo_q) && $stable(rd_q) && $stable(ovf_q)));

endmodule

// File: tb/hilo_muldiv_tb.sv
`timescale 1ns/1ps
module hilo_muldiv_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic        busy_o, ovf_o;
  logic [31:0] rd_data_o, hi_o, lo_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hilo_muldiv u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .busy_o    (busy_o),
    .rd_data_o (rd_data_o),
    .ovf_o     (ovf_o),
    .hi_o      (hi_o),
    .lo_o      (lo_o)
  );

  // {op, a, b, exp_hi, exp_lo, exp_rd, exp_ovf, check_rd}
  localparam int NV = 33;
  localparam logic [165:0] VEC [NV] = '{
    {4'd0,  32'h00000002, 32'hFFFFFFFD, 32'hFFFFFFFF, 32'hFFFFFFFA, 32'h0,        1'b0, 1'b0},
    {4'd1,  32'h00000002, 32'hFFFFFFFD, 32'h00000001, 32'hFFFFFFFA, 32'h0,        1'b0, 1'b0},
    {4'd8,  32'h0,        32'h0,        32'h00000001, 32'hFFFFFFFA, 32'h00000001, 1'b0, 1'b1},
    {4'd9,  32'h0,        32'h0,        32'h00000001, 32'hFFFFFFFA, 32'hFFFFFFFA, 1'b0, 1'b1},
    {4'd0,  32'h0000000C, 32'h00000005, 32'h00000000, 32'h0000003C, 32'h0,        1'b0, 1'b0},
    {4'd4,  32'h7FFFFFFF, 32'h7FFFFFFF, 32'h3FFFFFFF, 32'h0000003D, 32'h0,        1'b0, 1'b0},
    {4'd4,  32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFE, 32'h0000003E, 32'h0,        1'b0, 1'b0},
    {4'd4,  32'h7FFFFFFF, 32'h7FFFFFFF, 32'hBFFFFFFD, 32'h0000003F, 32'h0,        1'b0, 1'b0},
    {4'd6,  32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFE, 32'h0000003E, 32'h0,        1'b0, 1'b0},
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
    {4'd7,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 32'h0,        1'b0, 1'b0},
    {4'd5,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
    {4'd5,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000000, 32'h0,        1'b0, 1'b0},
    {4'd6,  32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE, 32'h00000002, 32'h0,        1'b0, 1'b0},
    {4'd10, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFFE, 32'h00000002, 32'h00000001, 1'b0, 1'b1},
    {4'd11, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFFE, 32'h00000002, 32'h00000001, 1'b1, 1'b1},
    {4'd11, 32'hFFFF8000, 32'h00010000, 32'hFFFFFFFE, 32'h00000002, 32'h80000000, 1'b0, 1'b1},
    {4'd11, 32'h00008000, 32'h00010000, 32'hFFFFFFFE, 32'h00000002, 32'h80000000, 1'b1, 1'b1},
    {4'd12, 32'h00008000, 32'h00010000, 32'hFFFFFFFE, 32'h00000002, 32'h80000000, 1'b0, 1'b1},
    {4'd11, 32'h00000002, 32'hFFFFFFFD, 32'hFFFFFFFE, 32'h00000002, 32'hFFFFFFFA, 1'b0, 1'b1},
    {4'd12, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE, 32'h00000002, 32'hFFFFFFFE, 1'b1, 1'b1},
    {4'd15, 32'h00000005, 32'h00000005, 32'hFFFFFFFE, 32'h00000002, 32'hFFFFFFFE, 1'b1, 1'b1},
    {4'd10, 32'h00000003, 32'h00000004, 32'hFFFFFFFE, 32'h00000002, 32'h0000000C, 1'b0, 1'b1},
    {4'd3,  32'h00000009, 32'h00000004, 32'h00000001, 32'h00000002, 32'h0,        1'b0, 1'b0},
    {4'd2,  32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'h0,        1'b0, 1'b0},
    {4'd2,  32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD, 32'h0,        1'b0, 1'b0},
    {4'd3,  32'hFFFFFFF9, 32'h00000002, 32'h00000001, 32'h7FFFFFFC, 32'h0,        1'b0, 1'b0},
    {4'd2,  32'h0000002C, 32'h0000001C, 32'h00000010, 32'h00000001, 32'h0,        1'b0, 1'b0},
    {4'd2,  32'hFFFFFFF7, 32'hFFFFFFFC, 32'hFFFFFFFF, 32'h00000002, 32'h0,        1'b0, 1'b0},
    {4'd2,  32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h0,        1'b0, 1'b0},
    {4'd2,  32'hFFFFFFF9, 32'h00000000, 32'hFFFFFFF9, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
    {4'd3,  32'h00000123, 32'h00000000, 32'h00000123, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
    {4'd8,  32'h0,        32'h0,        32'h00000123, 32'hFFFFFFFF, 32'h00000123, 1'b0, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] o, input logic [31:0] dv);
    case (o)
      4'd0, 4'd1:             return "R2";
      4'd2, 4'd3:             return (dv == 32'h0) ? "R4" : "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8, 4'd9:             return "R6";
      4'd10:                  return "R7";
      4'd11:                  return "R8";
      4'd12:                  return "R9";
      default:                return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; start = 1'b0; op = 4'd0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11", "hi", hi_o, 32'h0);
    check("R11", "lo", lo_o, 32'h0);
    check("R11", "rd", rd_data_o, 32'h0);
    check("R11", "ovf", {31'h0, ovf_o}, 32'h0);
    check("R11", "busy", {31'h0, busy_o}, 32'h0);

    // R1 operands without start strobe have no effect
    op = 4'd0; a = 32'h5; b = 32'h7; start = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "hi no start", hi_o, 32'h0);
    check("R1", "lo no start", lo_o, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [165:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[165:162], v[129:98]);
      run_op(v[165:162], v[161:130], v[129:98]);
      check(t, "hi", hi_o, v[97:66]);
      check(t, "lo", lo_o, v[65:34]);
      if (v[0]) begin
        check(t, "rd", rd_data_o, v[33:2]);
        check(t, "ovf", {31'h0, ovf_o}, {31'h0, v[1]});
      end
    end

    // R10 busy window and requests dropped while busy (100 / 7 = 14 r 2)
    n = 0;
    @(negedge clk);
    start = 1'b1; op = 4'd3; a = 32'd100; b = 32'd7;
    @(negedge clk);
    if (busy_o) n++;
    op = 4'd0; a = 32'h3; b = 32'h3;
    @(negedge clk);
    if (busy_o) n++;
    op = 4'd8;
    @(negedge clk);
    if (busy_o) n++;
    start = 1'b0;
    while (busy_o) begin
      @(negedge clk);
      if (busy_o) n++;
    end
    check("R10", "busy cycles", n, 32'd33);
    check("R10", "hi after ignored ops", hi_o, 32'h2);
    check("R10", "lo after ignored ops", lo_o, 32'hE);
    check("R10", "rd after ignored read", rd_data_o, 32'h123);

    // R11 reset during a divide clears without a clock edge
    @(negedge clk);
    start = 1'b1; op = 4'd2; a = 32'd1000; b = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11", "busy in reset", {31'h0, busy_o}, 32'h0);
    check("R11", "hi in reset", hi_o, 32'h0);
    check("R11", "lo in reset", lo_o, 32'h0);
    check("R11", "rd in reset", rd_data_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(4'd1, 32'h3, 32'h5);
    check("R2", "lo after reset release", lo_o, 32'hF);
    check("R2", "hi after reset release", hi_o, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule